// File: doc/BRIEF.md
# MSI Doorbell to Interrupt-Line Translator

This block sits behind a 4 KB register window. It turns message-signalled interrupt writes into pulses on a bank of wired interrupt lines. A device signals an interrupt by writing an absolute interrupt number to a doorbell register. The block subtracts the start of its assigned range from that number. When the result falls inside the range, the block raises the matching output for one clock cycle. Writes that fall outside the range, go to the wrong place or use an unsupported width have no effect.

Software discovers the assigned range by reading a capability word. That word packs the first interrupt number and the line count. An identification word and a block of zero-valued ID words are also readable. Two elaboration-time parameters fix the range: `BASE_IRQ` and `NUM_LINES`. The first interrupt number is `BASE_IRQ + 32`. Register data is little-endian, and byte 0 sits in bits 7:0.

Top module: `msi_irq_bridge`

## Requirements
- R1: A 4-byte read of offset 0x008 returns `((BASE_IRQ+32) << 16) | NUM_LINES`.
- R2: A 4-byte read of offset 0xFCC returns 0x05100000, which is the value 0x51 placed from bit 20 upward.
- R3: A 4-byte read of any offset from 0xFD0 to 0xFFC returns zero, and so does a read of any other offset except 0x008 and 0xFCC.
- R4: `req_size` carries the access width in bytes (1 to 4). A read with any width other than 4 returns zero, even at 0x008 or 0xFCC.
- R5: `rsp_valid` goes high in the cycle right after a read request, with `rsp_rdata` valid in that cycle. It is low in every other cycle.
- R6: A 2-byte or 4-byte write to offset 0x040 takes `req_wdata[9:0]` as an interrupt number N. When `BASE_IRQ+32 <= N < BASE_IRQ+32+NUM_LINES`, output `irq_pulse[N-BASE_IRQ-32]` is high for exactly the cycle after the write.
- R7: A doorbell write whose N is outside that range raises no output. Data bits 31:10 never affect which line fires.
- R8: A write of width 1 or 3, or a write to any offset other than 0x040, raises no output.
- R9: Each accepted doorbell write produces one pulse cycle. Back-to-back accepted writes produce one high cycle each, and at most one output is high in any cycle.
- R10: While `rst_n` is low and in the first cycle after it rises, all of `irq_pulse` and `rsp_valid` are low.
- R11: Elaboration rejects a parameter set with `NUM_LINES` outside 1..128, or with `BASE_IRQ+32+NUM_LINES` greater than 1020.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the window |
| req_wdata | input | 32 | Write data, little-endian |
| req_size | input | 3 | Access width in bytes (1 to 4) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses |

## Verification
The hardest case to reach from the ports is a doorbell write that lands exactly on one of the two range edges. It has to arrive with a legal width while the upper data bits carry garbage, and it often has to follow another accepted write with no idle cycle between them. Directed writes cover both edge numbers, the numbers just outside each edge, the upper-bit pattern and a back-to-back pair. Random writes then aim interrupt numbers at a small window around the range, so that the edges are hit many times under mixed widths and offsets.

// File: rtl/msi_irq_bridge.sv
module msi_irq_bridge #(
  parameter int unsigned BASE_IRQ  = 0,
  parameter int unsigned NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [11:0]          req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [2:0]           req_size,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_LINES-1:0] irq_pulse
);

  localparam int unsigned FIRST_ID = BASE_IRQ + 32;
  localparam int unsigned END_ID   = FIRST_ID + NUM_LINES;
  localparam int unsigned IDXW     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [31:0] TYPE_WORD  = (32'(FIRST_ID) << 16) | 32'(NUM_LINES);
  localparam logic [31:0] IDENT_WORD = 32'h51 << 20;
  localparam logic [11:0] ADDR_TYPE  = 12'h008;
  localparam logic [11:0] ADDR_DOOR  = 12'h040;
  localparam logic [11:0] ADDR_IDENT = 12'hFCC;

  initial begin
    assert_cfg_legal_R11: assert (NUM_LINES >= 1 && NUM_LINES <= 128 && END_ID <= 1020)
      else $error("msi_irq_bridge: illegal BASE_IRQ/NUM_LINES combination");
  end

  wire       rd_req = req_valid & ~req_write;
  wire       wr_req = req_valid & req_write;
  wire [9:0] msg_id = req_wdata[9:0];
  wire       unused_hi = ^req_wdata[31:10];

  wire wr_size_ok  = (req_size == 3'd2) || (req_size == 3'd4);
  wire id_in_range = (32'(msg_id) >= FIRST_ID) && (32'(msg_id) < END_ID);
  wire [IDXW-1:0] line_idx = IDXW'(msg_id - 10'(FIRST_ID));
  wire ring = wr_req & wr_size_ok & (req_addr == ADDR_DOOR) & id_in_range;

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (req_size == 3'd4) begin
      case (req_addr)
        ADDR_TYPE:  rd_word = TYPE_WORD;
        ADDR_IDENT: rd_word = IDENT_WORD;
        default:    rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      irq_pulse <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_word : '0;
      irq_pulse <= ring ? (NUM_LINES'(1) << line_idx) : '0;
    end
  end

  assert_pulse_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));

  assert_rsp_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  assert_rsp_only_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_req));

  assert_badsize_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_size) != 3'd4) |-> (rsp_rdata == 32'd0));

  assert_pulse_needs_doorbell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> $past(wr_req && req_addr == ADDR_DOOR && req_size != 3'd1 && req_size != 3'd3));

  assert_first_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && req_addr == ADDR_DOOR && req_size == 3'd4 && msg_id == 10'(FIRST_ID)) |=> irq_pulse[0]);

endmodule

// File: tb/test_msi_irq_bridge.sv
`timescale 1ns/1ps
module test_msi_irq_bridge;
  localparam int unsigned BASE = 10;
  localparam int unsigned NUM  = 20;
  localparam int unsigned FIRST = BASE + 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [2:0] req_size = 3'd4;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NUM-1:0] irq_pulse;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  msi_irq_bridge #(.BASE_IRQ(BASE), .NUM_LINES(NUM)) i_msi_irq_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_pulse(irq_pulse));

  function automatic logic [31:0] exp_read(logic [11:0] a, logic [2:0] s);
    if (s != 3'd4) return 32'd0;
    if (a == 12'h008) return (32'(FIRST) << 16) | 32'(NUM);
    if (a == 12'hFCC) return 32'h0510_0000;
    return 32'd0;
  endfunction

  function automatic logic [NUM-1:0] exp_pulse(logic [11:0] a, logic [31:0] d, logic [2:0] s);
    int n;
    n = int'(d[9:0]);
    if (a != 12'h040 || !(s == 3'd2 || s == 3'd4)) return '0;
    if (n < int'(FIRST) || n >= int'(FIRST + NUM)) return '0;
    return NUM'(1) << (n - int'(FIRST));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(string tag, logic w, logic [11:0] a, logic [31:0] d, logic [2:0] s);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_size = s;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'(!w));
    if (!w) check({tag, " rdata"}, rsp_rdata, exp_read(a, s));
    check({tag, " pulse"}, 32'(irq_pulse), 32'(w ? exp_pulse(a, d, s) : '0));
  endtask

  task automatic idle_check(string tag);
    @(posedge clk);
    @(negedge clk);
    check({tag, " idle pulse"}, 32'(irq_pulse), 32'd0);
    check({tag, " idle rsp"}, 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset pulse", 32'(irq_pulse), 32'd0);
    check("R10 reset rsp", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 after reset pulse", 32'(irq_pulse), 32'd0);
    check("R10 after reset rsp", 32'(rsp_valid), 32'd0);

    do_op("R1 type", 1'b0, 12'h008, 0, 3'd4);
    check("R1 literal", rsp_rdata, 32'h002A_0014);
    do_op("R2 ident", 1'b0, 12'hFCC, 0, 3'd4);
    do_op("R3 FD0", 1'b0, 12'hFD0, 0, 3'd4);
    do_op("R3 FFC", 1'b0, 12'hFFC, 0, 3'd4);
    do_op("R3 other", 1'b0, 12'h100, 0, 3'd4);
    do_op("R3 doorbell read", 1'b0, 12'h040, 0, 3'd4);
    do_op("R4 ident size2", 1'b0, 12'hFCC, 0, 3'd2);
    do_op("R4 type size1", 1'b0, 12'h008, 0, 3'd1);
    idle_check("R5");

    do_op("R6 first line", 1'b1, 12'h040, FIRST, 3'd4);
    check("R6 first literal", 32'(irq_pulse), 32'd1);
    idle_check("R6 one cycle");
    do_op("R6 last line size2", 1'b1, 12'h040, FIRST + NUM - 1, 3'd2);
    do_op("R7 below", 1'b1, 12'h040, FIRST - 1, 3'd4);
    do_op("R7 above", 1'b1, 12'h040, FIRST + NUM, 3'd4);
    do_op("R7 upper bits", 1'b1, 12'h040, 32'hFFFF_FC00 | FIRST + 3, 3'd4);
    do_op("R8 size1", 1'b1, 12'h040, FIRST + 2, 3'd1);
    do_op("R8 size3", 1'b1, 12'h040, FIRST + 2, 3'd3);
    do_op("R8 offset", 1'b1, 12'h044, FIRST + 2, 3'd4);
    do_op("R9 b2b first", 1'b1, 12'h040, FIRST + 5, 3'd4);
    do_op("R9 b2b second", 1'b1, 12'h040, FIRST + 5, 3'd4);
    idle_check("R9 after pair");

    for (int i = 0; i < 600; i++) begin
      logic w;
      logic [11:0] a;
      logic [31:0] d;
      logic [2:0] s;
      w = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 5))
        0: a = 12'h008;
        1: a = 12'hFCC;
        2: a = 12'h040;
        3: a = 12'h040;
        4: a = 12'hFD0 + 12'(4 * $urandom_range(0, 11));
        default: a = 12'($urandom_range(0, 4095));
      endcase
      d = $urandom;
      d[9:0] = 10'(FIRST - 3 + $urandom_range(0, NUM + 5));
      s = 3'($urandom_range(1, 4));
      do_op(w ? "R6 random write" : "R3 random read", w, a, d, s);
    end
    idle_check("R9 end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule